// File: doc/BRIEF.md
# Watchdog Countdown Timer Peripheral

This block is a watchdog timer for a system-on-chip, programmed through a plain 32-bit register port. Software loads a reload count, chooses a prescaler that divides an external one-microsecond base tick down to a slower count rate (a prescaler of 1000 gives one count per millisecond), and sets an enable bit. From then on it must restart the countdown periodically by writing a restart bit. If the count runs out while the timer is enabled, the block raises a reset request towards the chip reset network for a fixed number of clock cycles, and sets a sticky flag that records the watchdog as the cause of the reset.

The block is held in reset only by power-on reset, so the cause flag survives the reset it requests. Software reads it after reboot to tell a watchdog reboot from any other, and clears it by writing a one to it. Clearing the enable bit freezes the countdown without any reset, and a new reload value is only picked up at the next restart or automatic reload, so it can be written at any time without disturbing a running countdown.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset every register reads zero and the reset request output is low.
- R2: The control register at offset 0x20 reads back the enable bit at bit 7 and the prescaler at bits 16 upward (PRESC_W bits); the load register at 0x24 reads back its low CNT_W bits; all other bits, and the whole restart register at 0x00, read zero.
- R3: With load N and prescaler P, the reset request rises N×P base ticks after the edge on which the enable bit is written to 1, counted from that edge.
- R4: A write to offset 0x00 with bit 9 set reloads the countdown from the load register and restarts the prescaler, so the next expiry comes N×P base ticks after that write.
- R5: Writing the load register while counting leaves the running count alone; the new value is used at the next restart or automatic reload.
- R6: Writing the enable bit to 0 freezes the count with no reset request and no cause flag; writing it back to 1 resumes from the frozen count with a full prescaler period.
- R7: On expiry the reset request goes high on the following cycle and stays high for exactly PULSE_CYC clock cycles (a new expiry during the pulse restarts it).
- R8: Expiry sets the cause flag, read at bit 1 of offset 0x28; it stays set until a write of 1 to that bit clears it; a write of 0 has no effect.
- R9: A prescaler of 0 behaves as 1 (one count per base tick); a prescaler of 1000 gives one count per 1000 base ticks.
- R10: Clock cycles without a base tick do not advance the prescaler or the count.
- R11: A write to offset 0x00 with bit 9 clear has no effect on the countdown.
- R12: Writes to offsets other than 0x00, 0x20, 0x24 and 0x28 change nothing, and reads of them return zero.
- R13: After an expiry the count reloads from the load register and keeps running; a load of 0 expires on every count tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| base_tick_i | input | 1 | One-cycle pulse at the base (microsecond) rate |
| bus_we_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte offset of the register for read and write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| wdog_rst_o | output | 1 | Reset request towards the chip reset network |

## Verification
The bench builds the block with PRESC_W=16 and CNT_W=16, so the full register layout is exercised, and PULSE_CYC=5, which keeps each reset pulse shorter than the gap between two automatic reloads and lets back-to-back expiries be timed one by one. Prescalers of 0, 2, 4 and 8 bring expiry within tens of cycles, so restart, freeze and mid-count load writes can be placed at exact cycles, while one run with the 1000 setting checks the millisecond division end to end. The base tick is held high except in one window where it is dropped for ten cycles to shift the expiry by exactly that amount.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Bus geometry
    localparam int unsigned BUS_DW = 32;
    localparam int unsigned BUS_AW = 8;

    // Register offsets (software-visible, fixed)
    localparam logic [BUS_AW-1:0] ADDR_KICK  = 8'h00;
    localparam logic [BUS_AW-1:0] ADDR_CTRL  = 8'h20;
    localparam logic [BUS_AW-1:0] ADDR_LOAD  = 8'h24;
    localparam logic [BUS_AW-1:0] ADDR_CAUSE = 8'h28;

    // Field positions
    localparam int unsigned CTRL_EN_BIT    = 7;
    localparam int unsigned CTRL_PRESC_LSB = 16;
    localparam int unsigned KICK_BIT       = 9;
    localparam int unsigned CAUSE_BIT      = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_KICK,
        SEL_CTRL,
        SEL_LOAD,
        SEL_CAUSE
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(input logic [BUS_AW-1:0] a);
        reg_sel_e s;
        case (a)
            ADDR_KICK:  s = SEL_KICK;
            ADDR_CTRL:  s = SEL_CTRL;
            ADDR_LOAD:  s = SEL_LOAD;
            ADDR_CAUSE: s = SEL_CAUSE;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned PRESC_W = 16,
    parameter int unsigned CNT_W   = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  bus_req_t           req_i,
    input  logic               cause_i,
    output logic [BUS_DW-1:0]  rdata_o,
    output logic               en_o,
    output logic [PRESC_W-1:0] presc_o,
    output logic [CNT_W-1:0]   load_o,
    output logic               kick_o,
    output logic               restart_o,
    output logic               cause_clr_o
);

    typedef struct packed {
        logic               en;
        logic [PRESC_W-1:0] presc;
        logic [CNT_W-1:0]   load;
    } regs_t;

    regs_t    s_d, s_q;
    reg_sel_e sel;
    logic     ctrl_wr;

    always_comb begin
        sel         = decode_addr(req_i.addr);
        s_d         = s_q;
        kick_o      = 1'b0;
        ctrl_wr     = 1'b0;
        cause_clr_o = 1'b0;

        if (req_i.we) begin
            case (sel)
                SEL_CTRL: begin
                    s_d.en    = req_i.wdata[CTRL_EN_BIT];
                    s_d.presc = req_i.wdata[CTRL_PRESC_LSB +: PRESC_W];
                    ctrl_wr   = 1'b1;
                end
                SEL_LOAD:  s_d.load   = req_i.wdata[CNT_W-1:0];
                SEL_KICK:  kick_o      = req_i.wdata[KICK_BIT];
                SEL_CAUSE: cause_clr_o = req_i.wdata[CAUSE_BIT];
                default: ;
            endcase
        end

        restart_o = kick_o | ctrl_wr;

        rdata_o = '0;
        case (sel)
            SEL_CTRL: begin
                rdata_o[CTRL_EN_BIT]                  = s_q.en;
                rdata_o[CTRL_PRESC_LSB +: PRESC_W]    = s_q.presc;
            end
            SEL_LOAD:  rdata_o[CNT_W-1:0] = s_q.load;
            SEL_CAUSE: rdata_o[CAUSE_BIT] = cause_i;
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign en_o    = s_q.en;
    assign presc_o = s_q.presc;
    assign load_o  = s_q.load;

    // Writes to unmapped offsets leave every register as it was
    assert_unmapped_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i.we && sel == SEL_NONE) |=> $stable(s_q));

    // A restart-register write without the restart bit starts nothing
    assert_kick_needs_bit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i.we && sel == SEL_KICK && !req_i.wdata[KICK_BIT]) |-> !restart_o);

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int unsigned PRESC_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               base_tick_i,
    input  logic               run_i,
    input  logic               restart_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic               tick_o
);

    typedef struct packed {
        logic [PRESC_W-1:0] div;
    } div_t;

    div_t           s_d, s_q;
    logic [PRESC_W:0] span;
    logic [PRESC_W:0] next_div;
    logic             wrap;

    always_comb begin
        span     = (presc_i == '0) ? {{PRESC_W{1'b0}}, 1'b1} : {1'b0, presc_i};
        next_div = {1'b0, s_q.div} + 1'b1;
        wrap     = (next_div >= span);
        s_d      = s_q;
        tick_o   = 1'b0;

        if (restart_i) begin
            s_d.div = '0;
        end else if (run_i && base_tick_i) begin
            if (wrap) begin
                s_d.div = '0;
                tick_o  = 1'b1;
            end else begin
                s_d.div = next_div[PRESC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // Divider never passes the programmed span
    assert_div_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ({1'b0, s_q.div} < span));

    // Without a base tick the divider does not move
    assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!base_tick_i && !restart_i) |=> $stable(s_q.div));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        expire_o = 1'b0;
        if (kick_i) begin
            s_d.cnt = load_i;
        end else if (tick_i && en_i) begin
            if (s_q.cnt <= CNT_W'(1)) begin
                expire_o = 1'b1;
                s_d.cnt  = load_i;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // Restart loads the programmed count
    assert_kick_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick_i |=> (s_q.cnt == $past(load_i)));

    // Disabled timer holds its count
    assert_frozen_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !kick_i) |=> $stable(s_q.cnt));

endmodule

// File: rtl/wdog_resetgen.sv
module wdog_resetgen #(
    parameter int unsigned PULSE_CYC = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic expire_i,
    input  logic cause_clr_i,
    output logic rst_req_o,
    output logic cause_o
);

    localparam int unsigned PULSE_W = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic [PULSE_W-1:0] left;
        logic               cause;
    } gen_t;

    gen_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (expire_i)             s_d.left = PULSE_W'(PULSE_CYC);
        else if (s_q.left != '0)  s_d.left = s_q.left - 1'b1;
        s_d.cause = expire_i | (s_q.cause & ~cause_clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rst_req_o = (s_q.left != '0);
    assign cause_o   = s_q.cause;

    // Expiry raises the request and the cause flag on the next cycle
    assert_expire_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_i |=> (rst_req_o && s_q.cause));

    // Cause flag is sticky until software clears it
    assert_cause_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.cause && !cause_clr_i) |=> s_q.cause);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned PRESC_W   = 16,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PULSE_CYC = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              base_tick_i,
    input  logic              bus_we_i,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic [BUS_DW-1:0] bus_wdata_i,
    output logic [BUS_DW-1:0] bus_rdata_o,
    output logic              wdog_rst_o
);

    bus_req_t           req;
    logic               en;
    logic [PRESC_W-1:0] presc;
    logic [CNT_W-1:0]   load;
    logic               kick;
    logic               restart;
    logic               cause_clr;
    logic               cause;
    logic               tick;
    logic               expire;

    assign req = '{we: bus_we_i, addr: bus_addr_i, wdata: bus_wdata_i};

    wdog_regs #(
        .PRESC_W (PRESC_W),
        .CNT_W   (CNT_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_i       (req),
        .cause_i     (cause),
        .rdata_o     (bus_rdata_o),
        .en_o        (en),
        .presc_o     (presc),
        .load_o      (load),
        .kick_o      (kick),
        .restart_o   (restart),
        .cause_clr_o (cause_clr)
    );

    wdog_prescaler #(
        .PRESC_W (PRESC_W)
    ) u_presc (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .base_tick_i (base_tick_i),
        .run_i       (en),
        .restart_i   (restart),
        .presc_i     (presc),
        .tick_o      (tick)
    );

    wdog_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (en),
        .tick_i   (tick),
        .kick_i   (kick),
        .load_i   (load),
        .expire_o (expire)
    );

    wdog_resetgen #(
        .PULSE_CYC (PULSE_CYC)
    ) u_rstgen (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .expire_i    (expire),
        .cause_clr_i (cause_clr),
        .rst_req_o   (wdog_rst_o),
        .cause_o     (cause)
    );

    // No reset request can start while the timer is disabled
    assert_no_expire_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en && !wdog_rst_o) |=> !wdog_rst_o);

endmodule

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;

    localparam int unsigned PULSE = 5;
    localparam logic [7:0] A_KICK = 8'h00, A_CTRL = 8'h20, A_LOAD = 8'h24, A_CAUSE = 8'h28;
    localparam logic [31:0] EN = 32'h80, KICKV = 32'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_tick = 1'b1;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wd_rst;

    int n_chk = 0, n_fail = 0, cyc = 0, rises = 0, hi_len = 0;
    bit prev = 1'b0, done = 1'b0;

    typedef struct { int at; string req; } exp_t;
    exp_t exp_q[$];

    wdog_timer #(.PRESC_W(16), .CNT_W(16), .PULSE_CYC(PULSE)) dut (
        .clk_i(clk), .rst_ni(rst_n), .base_tick_i(base_tick), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .wdog_rst_o(wd_rst)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, output int e);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); e = cyc; we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] r);
        @(negedge clk); addr = a; #1; r = rdata;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic push(input int at, input string req);
        exp_t it; it.at = at; it.req = req; exp_q.push_back(it);
    endtask

    // Monitor: pops expected expiries and measures pulse length
    always @(negedge clk) begin
        if (rst_n) begin
            if (wd_rst && !prev) begin
                rises++;
                if (exp_q.size() == 0) chk("R6", "unexpected reset request", 32'(cyc), 32'hFFFFFFFF);
                else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    chk(it.req, "reset request rise cycle", 32'(it.at == cyc ? it.at : cyc), 32'(it.at));
                end
            end
            if (wd_rst) hi_len++;
            else if (prev) begin
                chk("R7", "reset pulse length", 32'(hi_len), 32'(PULSE));
                hi_len = 0;
            end
            prev = wd_rst;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        int e, w, k, d, r0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1", "reset request after reset", 32'(wd_rst), 0);
        rd(A_CTRL, r);  chk("R1", "ctrl after reset", r, 0);
        rd(A_LOAD, r);  chk("R1", "load after reset", r, 0);
        rd(A_CAUSE, r); chk("R1", "cause after reset", r, 0);

        // R2: readback masks (enable left at 0)
        wr(A_CTRL, 32'hFFFF_FF7F, e); rd(A_CTRL, r); chk("R2", "ctrl readback", r, 32'hFFFF_0000);
        wr(A_LOAD, 32'hFFFF_FFFF, e); rd(A_LOAD, r); chk("R2", "load readback", r, 32'h0000_FFFF);
        wr(A_KICK, 32'hFFFF_FFFF, e); rd(A_KICK, r); chk("R2", "restart reg reads zero", r, 0);

        // R12: unmapped offsets
        wr(8'h10, 32'hFFFF_FFFF, e); wr(8'h21, 32'h0, e); wr(8'h2C, 32'h0, e);
        rd(A_CTRL, r); chk("R12", "ctrl after unmapped writes", r, 32'hFFFF_0000);
        rd(A_LOAD, r); chk("R12", "load after unmapped writes", r, 32'h0000_FFFF);
        rd(8'h10, r);  chk("R12", "unmapped read", r, 0);

        // R3 / R13 / R8: basic expiry, auto reload, cause flag
        wr(A_CTRL, 32'h0004_0000, e); wr(A_LOAD, 5, e); wr(A_KICK, KICKV, e);
        wr(A_CTRL, 32'h0004_0000 | EN, w);
        push(w + 20, "R3"); push(w + 40, "R13");
        rd(A_CTRL, r); chk("R2", "ctrl shows running", r, 32'h0004_0080);
        drain();
        wr(A_CTRL, 32'h0004_0000, e);
        rd(A_CAUSE, r); chk("R8", "cause set by expiry", r, 32'h2);
        wr(A_CAUSE, 0, e); rd(A_CAUSE, r); chk("R8", "cause kept on write 0", r, 32'h2);
        wr(A_CAUSE, 32'h2, e); rd(A_CAUSE, r); chk("R8", "cause cleared on write 1", r, 0);

        // R11: restart register write without bit 9
        wr(A_KICK, KICKV, e); wr(A_CTRL, 32'h0004_0000 | EN, w);
        push(w + 20, "R11");
        wait_until(w + 6); wr(A_KICK, 32'hFFFF_FDFF, e);
        drain(); wr(A_CTRL, 32'h0004_0000, e);

        // R4: restart mid-count
        wr(A_KICK, KICKV, e); wr(A_CTRL, 32'h0004_0000 | EN, w);
        wait_until(w + 12); wr(A_KICK, KICKV, k);
        push(k + 20, "R4");
        drain(); wr(A_CTRL, 32'h0004_0000, e);

        // R5: load write while running
        wr(A_KICK, KICKV, e); wr(A_CTRL, 32'h0004_0000 | EN, w);
        push(w + 20, "R5");
        wait_until(w + 6); wr(A_LOAD, 2, e);
        push(w + 28, "R5");
        drain(); wr(A_CTRL, 32'h0004_0000, e);

        // R6: freeze and resume
        wr(A_LOAD, 5, e); wr(A_CAUSE, 32'h2, e); wr(A_KICK, KICKV, e);
        wr(A_CTRL, 32'h0004_0000 | EN, w);
        wait_until(w + 7); wr(A_CTRL, 32'h0004_0000, d);
        r0 = rises;
        repeat (100) @(negedge clk);
        chk("R6", "no reset while disabled", 32'(rises), 32'(r0));
        rd(A_CAUSE, r); chk("R6", "no cause while disabled", r, 0);
        wr(A_CTRL, 32'h0004_0000 | EN, w);
        push(w + 12, "R6");
        drain(); wr(A_CTRL, 32'h0004_0000, e);

        // R9: prescaler 0 and 1000
        wr(A_LOAD, 4, e); wr(A_KICK, KICKV, e); wr(A_CTRL, EN, w);
        push(w + 4, "R9");
        drain(); wr(A_CTRL, 0, e);
        wr(A_LOAD, 2, e); wr(A_KICK, KICKV, e); wr(A_CTRL, (32'd1000 << 16) | EN, w);
        push(w + 2000, "R9");
        drain(); wr(A_CTRL, 0, e);

        // R10: base tick held low for ten cycles
        wr(A_LOAD, 3, e); wr(A_KICK, KICKV, e); wr(A_CTRL, 32'h0002_0000 | EN, w);
        push(w + 16, "R10");
        wait_until(w + 2); base_tick = 1'b0;
        repeat (10) @(negedge clk); base_tick = 1'b1;
        drain(); wr(A_CTRL, 0, e);

        // R13: load of zero expires on every count tick
        wr(A_LOAD, 0, e); wr(A_KICK, KICKV, e); wr(A_CTRL, 32'h0008_0000 | EN, w);
        push(w + 8, "R13"); push(w + 16, "R13");
        drain(); wr(A_CTRL, 0, e);

        repeat (20) @(negedge clk);
        chk("R3", "all expected expiries seen", 32'(exp_q.size()), 0);
        finish_run();
    end

endmodule